// File: doc/BRIEF.md
# Strided Dual-Stream Loop Engine with Multiply-Accumulate

This block runs one dot-product style loop, such as the inner sum of an FIR filter, next to a configurable fabric. Software programs two operand streams, c and x, each with a base byte address and a stride counted in words. It also programs an iteration count and then writes a go command. From then on, dedicated address-pointer logic and a loop counter run the whole loop. The datapath only multiplies and accumulates, so the critical loop needs no synthesized state machine of its own.

Each iteration reads one c word and then one x word through a simple request/response read port. Only one read is in flight at a time. The engine adds the low half of c*x to a 32-bit accumulator. When the last product has been added, the engine drops busy and raises done. The accumulator value is on the result output.

Top module: `loop_mac_engine`

## Requirements
- R1: After reset, busy, done, mem_req and result are all 0.
- R2: For iteration i (counting from 0), the engine reads the c word at cbase + 4*i*cstride and then the x word at xbase + 4*i*xstride. Reads strictly alternate c then x. Each read is one mem_req pulse whose address is on mem_addr in that cycle.
- R3: When done rises, result equals the sum over all iterations of c*x. Each product is truncated to 32 bits, and the sum wraps modulo 2^32.
- R4: A go command with a count of 0 raises done in the very next cycle and issues no read.
- R5: done stays high until the next accepted go command. It is low in the cycle after a go with a nonzero count.
- R6: Configuration writes, including go, are ignored while busy. Registers keep their values across runs, so a second go repeats the same loop.
- R7: At most one read is outstanding. After a mem_req pulse, the next mem_req comes only after mem_rvalid.
- R8: With a memory latency of L cycles from request to mem_rvalid, a count N>0 run raises done 2N(1+L)+1 negedges after the go edge. Negedges are counted from 1 at the first negedge after the go edge.
- R9: Address arithmetic wraps modulo 2^ADDR_W. Strides are two's complement, so a stride of 0 rereads one word and all-ones steps back one word.
- R10: Register indices on cfg_addr are: 0 c base, 1 c stride, 2 x base, 3 x stride, 4 count (low CNT_W bits), 5 go (data ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | ADDR_W | Configuration write data |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | Loop running |
| done | output | 1 | Loop finished, held until next go |
| result | output | DATA_W | Accumulated sum |

## Verification
The bench builds the engine with 32-bit addresses and data and an 8-bit count width. With that count width, a run at the full-scale count of 255 fits the cycle budget and reaches the counter's top value. The memory model's latency is switched between 1 and 3 cycles between runs, so the done timing is checked under more than one response delay. Negative and zero strides, address wrap below zero, and accumulator overflow are all reached with the default 32-bit widths.

// File: rtl/lme_pkg.sv
package lme_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} lme_state_e;

  typedef enum logic [2:0] {
    REG_CBASE = 3'd0,
    REG_CSTR  = 3'd1,
    REG_XBASE = 3'd2,
    REG_XSTR  = 3'd3,
    REG_COUNT = 3'd4,
    REG_GO    = 3'd5
  } lme_reg_e;
endpackage

// File: rtl/lme_addr_gen.sv
module lme_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NSTR   = 2,
  localparam int SEL_W = (NSTR > 1) ? $clog2(NSTR) : 1,
  localparam int WS    = $clog2(DATA_W / 8)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic [NSTR-1:0][ADDR_W-1:0]   base_i,
  input  logic [NSTR-1:0][ADDR_W-1:0]   stride_i,
  input  logic                          adv_i,
  input  logic [SEL_W-1:0]              sel_i,
  output logic [ADDR_W-1:0]             addr_o
);
  logic [NSTR-1:0][ADDR_W-1:0] ptr_q, ptr_n;

  for (genvar s = 0; s < NSTR; s++) begin : g_stream
    always_comb begin
      ptr_n[s] = ptr_q[s];
      if (load_i)
        ptr_n[s] = base_i[s];
      else if (adv_i && (sel_i == SEL_W'(s)))
        ptr_n[s] = ptr_q[s] + (stride_i[s] << WS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[s] <= '0;
      else        ptr_q[s] <= ptr_n[s];
    end
  end

  assign addr_o = ptr_q[sel_i];

  // R9
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && (sel_i == '0)) |=>
      (ptr_q[0] == $past(ptr_q[0]) + ($past(stride_i[0]) << WS)));
endmodule

// File: rtl/lme_loop_ctl.sv
module lme_loop_ctl
  import lme_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rvalid_i,
  output logic             req_o,
  output logic             phase_o,
  output logic             cap_o,
  output logic             mac_o,
  output logic             busy_o,
  output logic             done_o
);
  lme_state_e       st_q, st_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             ph_q, ph_n;
  logic             done_q, done_n;

  always_comb begin
    st_n   = st_q;
    rem_n  = rem_q;
    ph_n   = ph_q;
    done_n = done_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        if (count_i == '0) begin
          done_n = 1'b1;
        end else begin
          done_n = 1'b0;
          rem_n  = count_i;
          ph_n   = 1'b0;
          st_n   = ST_REQ;
        end
      end
      ST_REQ: st_n = ST_WAIT;
      ST_WAIT: if (rvalid_i) begin
        if (!ph_q) begin
          ph_n = 1'b1;
          st_n = ST_REQ;
        end else if (rem_q == CNT_W'(1)) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end else begin
          rem_n = rem_q - CNT_W'(1);
          ph_n  = 1'b0;
          st_n  = ST_REQ;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      rem_q  <= rem_n;
      ph_q   <= ph_n;
      done_q <= done_n;
    end
  end

  assign req_o   = (st_q == ST_REQ);
  assign phase_o = ph_q;
  assign cap_o   = (st_q == ST_WAIT) && rvalid_i && !ph_q;
  assign mac_o   = (st_q == ST_WAIT) && rvalid_i && ph_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;

  // R4
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (count_i == '0)) |=> (done_o && !busy_o && !req_o));

  // R7
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);
endmodule

// File: rtl/lme_mac.sv
module lme_mac #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              mac_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] c_q, c_n, acc_q, acc_n, prod;

  assign prod = c_q * data_i;

  always_comb begin
    c_n   = c_q;
    acc_n = acc_q;
    if (clr_i)      acc_n = '0;
    else if (mac_i) acc_n = acc_q + prod;
    if (cap_i)      c_n   = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q   <= '0;
      acc_q <= '0;
    end else begin
      c_q   <= c_n;
      acc_q <= acc_n;
    end
  end

  assign acc_o = acc_q;

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mac_i && !clr_i) |=> $stable(acc_o));
endmodule

// File: rtl/loop_mac_engine.sv
module loop_mac_engine
  import lme_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int NSTR = 2;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NSTR-1:0][ADDR_W-1:0] base_q, stride_q;
  logic [CNT_W-1:0]            count_q;
  logic                        wr_ok, go;
  logic                        phase, cap, mac;

  assign wr_ok = cfg_we && !busy;
  assign go    = wr_ok && (cfg_addr == REG_GO);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q   <= '0;
      stride_q <= '0;
      count_q  <= '0;
    end else if (wr_ok) begin
      case (cfg_addr)
        REG_CBASE: base_q[0]   <= cfg_wdata;
        REG_CSTR:  stride_q[0] <= cfg_wdata;
        REG_XBASE: base_q[1]   <= cfg_wdata;
        REG_XSTR:  stride_q[1] <= cfg_wdata;
        REG_COUNT: count_q     <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  lme_loop_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n), .start_i(go), .count_i(count_q),
    .rvalid_i(mem_rvalid), .req_o(mem_req), .phase_o(phase),
    .cap_o(cap), .mac_o(mac), .busy_o(busy), .done_o(done)
  );

  lme_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSTR(NSTR)) u_agen (
    .clk(clk), .rst_n(rst_sync_n), .load_i(go), .base_i(base_q),
    .stride_i(stride_q), .adv_i(mem_req), .sel_i(phase), .addr_o(mem_addr)
  );

  lme_mac #(.DATA_W(DATA_W)) u_mac (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(go), .cap_i(cap), .mac_i(mac),
    .data_i(mem_rdata), .acc_o(result)
  );

  // R6
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |=> ($stable(base_q) && $stable(stride_q) && $stable(count_q)));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !go) |=> done);

  // R7
  req_in_run_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req |-> busy);
endmodule

// File: tb/sim_loop_mac_engine.sv
module sim_loop_mac_engine;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          busy, done;
  logic [DW-1:0] result;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  int pending = 0;
  logic [AW-1:0] pend_addr = '0;
  logic [AW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  loop_mac_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .result(result)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return a * 32'h9E37_79B1 + 32'h7F4A_7C15;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // memory model and per-clock address comparison
  initial forever begin
    @(negedge clk);
    mem_rvalid = 1'b0;
    if (pending > 0) begin
      pending--;
      if (pending == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word(pend_addr);
      end
    end
    if (rst_n && mem_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R4 unexpected read", 64'(mem_addr), 64'hX);
      end else begin
        // R2 R9
        chk(mem_addr == exp_q[0], "R2 read address", 64'(mem_addr), 64'(exp_q[0]));
        void'(exp_q.pop_front());
      end
      // R7
      chk(pending == 0, "R7 outstanding read", 64'(pending), 64'd0);
      pending   = lat;
      pend_addr = mem_addr;
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    summary();
  end

  task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic [AW-1:0] cb, input logic [AW-1:0] cs,
                     input logic [AW-1:0] xb, input logic [AW-1:0] xs,
                     input int n, input int l, input bit busy_wr, input bit rewrite);
    logic [DW-1:0] sum;
    int k, exp_k;
    logic [AW-1:0] ca, xa;
    if (rewrite) begin
      wr(3'd0, cb); wr(3'd1, cs); wr(3'd2, xb); wr(3'd3, xs); wr(3'd4, AW'(n));
    end
    lat = l;
    sum = '0;
    for (int i = 0; i < n; i++) begin
      ca = cb + AW'(i) * (cs << 2);
      xa = xb + AW'(i) * (xs << 2);
      exp_q.push_back(ca);
      exp_q.push_back(xa);
      sum = sum + mem_word(ca) * mem_word(xa);
    end
    exp_k = (n == 0) ? 1 : 2 * n * (1 + l) + 1;
    wr(3'd5, '0);
    k = 1;
    if (n > 0)
      // R5
      chk(done == 1'b0, "R5 done cleared by go", 64'(done), 64'd0);
    while (!done && k < 5000) begin
      @(negedge clk);
      k++;
      if (busy_wr && k == 3) begin
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'hDEAD_0000;
      end
      if (busy_wr && k == 4) cfg_we = 1'b0;
    end
    // R8 / R4
    chk(k == exp_k, (n == 0) ? "R4 done timing" : "R8 done timing", 64'(k), 64'(exp_k));
    // R3
    chk(result == sum, "R3 result", 64'(result), 64'(sum));
    // R2 / R6
    chk(exp_q.size() == 0, "R2 all reads issued", 64'(exp_q.size()), 64'd0);
    chk(busy == 1'b0, "R8 busy low at done", 64'(busy), 64'd0);
    exp_q.delete();
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      // R5
      chk(done == 1'b1, "R5 done held", 64'(done), 64'd1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 0 && done == 0 && mem_req == 0 && result == 0,
        "R1 reset state", {busy, done, mem_req, result}, 64'd0);
    // R2 R3 R8 R10
    run(32'h1000, 32'd1, 32'h2000, 32'd1, 5, 1, 1'b0, 1'b1);
    // R4
    run(32'h1000, 32'd1, 32'h2000, 32'd1, 0, 1, 1'b0, 1'b1);
    // R8 with longer latency
    run(32'h4000, 32'd2, 32'h8000, 32'd3, 6, 3, 1'b0, 1'b1);
    // R6: write during run ignored, rerun reuses retained registers
    run(32'h0300, 32'd1, 32'h0500, 32'd2, 4, 1, 1'b1, 1'b1);
    run(32'h0300, 32'd1, 32'h0500, 32'd2, 4, 2, 1'b0, 1'b0);
    // R9: negative stride wraps below zero, zero stride rereads
    run(32'h0000_0008, 32'hFFFF_FFFF, 32'h0000_0040, 32'd0, 7, 1, 1'b0, 1'b1);
    // R3 full-scale count, accumulator wraps
    run(32'hF000_0000, 32'd5, 32'h7000_0000, 32'd7, 255, 1, 1'b0, 1'b1);
    summary();
  end
endmodule